// File: doc/BRIEF.md
# Prioritised Interrupt Vector Generator

This block stands between the interrupt request lines of the peripherals and the CPU. Each request line has a fixed priority number set by a parameter. A line counts as eligible when its request is high and its own enable is high. A maskable line must also have the global interrupt enable high. Lines marked non-maskable ignore the global enable, but their own enable still blocks them. The eligible line with the largest priority number wins. The block then gives the CPU the address of that line's vector table entry. The address is the table base plus twice the priority, because each entry is a 16-bit word.

When no interrupt is being presented, the block samples the eligible lines on each clock edge. On the edge that finds one, it captures the winner's index and vector address and raises the pending output. It then keeps that choice unchanged until the CPU acknowledges it. On the acknowledge edge, three things happen at once:
- the pending output falls;
- the chosen source gets a one-cycle acknowledge pulse, so a flag with a single source can clear itself in its peripheral;
- the global enable is cleared.

The interrupt flags stay inside the peripherals. A flag shared by several causes is cleared by its own peripheral, not by this block.

Top module: `irq_vector_gen`

## Requirements
- R1: During reset, and on the first cycle after it, the outputs are: `irq_pending` 0, `vec_addr` equal to the table base 0xFF80, `src_id` 0, `src_ack` all zero and `gie` 0.
- R2: The vector address is 0xFF80 + 2 × priority. With the default priorities (sources 0..5 = 60, 59, 54, 53, 49, 48), the addresses are 0xFFF8, 0xFFF6, 0xFFEC, 0xFFEA, 0xFFE2 and 0xFFE0.
- R3: When several sources are eligible, the one with the larger priority number is presented.
- R4: A maskable source never causes a pending interrupt while `gie` is 0, or while its own `irq_en` bit is 0.
- R5: A non-maskable source (default: source 5 only) is presented while `gie` is 0, but is blocked when its own `irq_en` bit is 0.
- R6: An eligible request sampled on an idle edge raises `irq_pending`, `vec_addr` and `src_id` after that edge. These then stay stable until the acknowledge, even if requests change or a higher-priority source arrives.
- R7: `irq_ack` sampled high while `irq_pending` is 1 has three effects after that edge: `irq_pending` drops, `src_ack` carries a single pulse of one cycle on bit `src_id`, and `gie` is 0.
- R8: `irq_ack` while nothing is pending has no effect: `src_ack` stays zero and `gie` keeps its value.
- R9: While nothing is pending, `vec_addr` keeps its last value.
- R10: `gie_set` sets `gie` on the next edge and `gie_clr` clears it. A clear, or an accepted acknowledge, wins over a set in the same cycle.
- R11: Arbitration restarts on the edge after the acknowledge. A source that is still eligible is presented again one cycle after `irq_pending` fell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Request lines from the peripherals, held high while their flag is set |
| irq_en | input | NUM_SRC | Per-source enable bits |
| gie_set | input | 1 | Pulse that sets the global interrupt enable |
| gie_clr | input | 1 | Pulse that clears the global interrupt enable |
| irq_ack | input | 1 | CPU acknowledge of the presented interrupt |
| irq_pending | output | 1 | An interrupt is being presented to the CPU |
| vec_addr | output | ADDR_W | Vector table address of the presented source |
| src_id | output | ID_W | Index of the presented source |
| src_ack | output | NUM_SRC | One-cycle acknowledge pulse, one bit per source |
| gie | output | 1 | Current global interrupt enable |

## Verification
The assertions assume that the inputs are synchronous to `clk` and that `irq_ack` is a single-cycle pulse. The bench drives every input just after a rising edge, so each value is settled well before the next edge samples it. It raises `irq_ack` for exactly one cycle each time, and never keeps it high across two edges. It also releases a request only after its acknowledge, as a peripheral would on clearing its flag. Reset is applied only at the start of the run, so the `$past` checks never reach back into cycles that reset has not defined.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_PRIO_W = 6;
  localparam logic [15:0] DEF_VEC_BASE = 16'hFF80;

  // Word-sized table entries: byte address = base + 2*priority
  function automatic logic [DEF_ADDR_W-1:0] vec_of(
      input logic [DEF_ADDR_W-1:0] base,
      input logic [DEF_ADDR_W-1:0] prio);
    return base + (prio << 1);
  endfunction
endpackage

// File: rtl/ivg_prio_arbiter.sv
module ivg_prio_arbiter #(
  parameter int unsigned NUM_SRC  = 6,
  parameter int unsigned PRIO_W   = 6,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = '0,
  localparam int unsigned ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] elig,
  output logic               win_valid,
  output logic [ID_W-1:0]    win_id,
  output logic [PRIO_W-1:0]  win_prio
);
  logic [PRIO_W-1:0] prio_tab [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prio_tab[g] = SRC_PRIO[g*PRIO_W +: PRIO_W];
  end

  // Ascending scan with strict compare: on equal priority the lower index stays
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_valid || prio_tab[i] > win_prio)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_prio  = prio_tab[i];
      end
    end
  end

  always_comb begin
    if (win_valid) begin
      assert_winner_eligible_R3: assert (elig[win_id]);
    end
  end
endmodule

// File: rtl/ivg_vector_calc.sv
module ivg_vector_calc #(
  parameter int unsigned PRIO_W = 6,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFF80
) (
  input  logic [PRIO_W-1:0] prio,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] offset;

  assign offset = ADDR_W'({prio, 1'b0});
  assign addr   = VEC_BASE + offset;
endmodule

// File: rtl/ivg_ack_decode.sv
module ivg_ack_decode #(
  parameter int unsigned NUM_SRC = 6,
  localparam int unsigned ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [ID_W-1:0]    id,
  output logic [NUM_SRC-1:0] ack_out
);
  logic [NUM_SRC-1:0] ack_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) ack_q[g] <= 1'b0;
      else     ack_q[g] <= fire && (id == ID_W'(g));
    end
  end

  assign ack_out = ack_q;

  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_q));
  assert_ack_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_q != '0) |=> (ack_q == '0));
endmodule

// File: rtl/ivg_gie_ctrl.sv
module ivg_gie_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic accept,
  output logic gie_q
);
  always_ff @(posedge clk) begin
    if (rst)                    gie_q <= 1'b0;
    else if (clr_req || accept) gie_q <= 1'b0;
    else if (set_req)           gie_q <= 1'b1;
  end

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_req || accept) |=> !gie_q);
  assert_set_takes_R10: assert property (@(posedge clk) disable iff (rst)
    (set_req && !clr_req && !accept) |=> gie_q);
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int unsigned NUM_SRC  = 6,
  parameter int unsigned PRIO_W   = ivg_pkg::DEF_PRIO_W,
  parameter int unsigned ADDR_W   = ivg_pkg::DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] VEC_BASE = ivg_pkg::DEF_VEC_BASE,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO =
    {6'd48, 6'd49, 6'd53, 6'd54, 6'd59, 6'd60},
  parameter logic [NUM_SRC-1:0] NMI_MASK = 6'b100000,
  localparam int unsigned ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               irq_ack,
  output logic               irq_pending,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [ID_W-1:0]    src_id,
  output logic [NUM_SRC-1:0] src_ack,
  output logic               gie
);
  logic               gie_q;
  logic               pend_q;
  logic [ID_W-1:0]    sel_q;
  logic [ADDR_W-1:0]  vec_q;
  logic [NUM_SRC-1:0] elig;
  logic               win_valid;
  logic [ID_W-1:0]    win_id;
  logic [PRIO_W-1:0]  win_prio;
  logic [ADDR_W-1:0]  win_addr;
  logic               accept;
  logic               win_is_nmi;

  // Global enable gates only maskable lines
  assign elig   = irq_req & irq_en & ({NUM_SRC{gie_q}} | NMI_MASK);
  assign accept = pend_q && irq_ack;

  ivg_prio_arbiter #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .SRC_PRIO(SRC_PRIO)
  ) u_arb (
    .elig     (elig),
    .win_valid(win_valid),
    .win_id   (win_id),
    .win_prio (win_prio)
  );

  ivg_vector_calc #(
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W),
    .VEC_BASE(VEC_BASE)
  ) u_vec (
    .prio(win_prio),
    .addr(win_addr)
  );

  ivg_ack_decode #(
    .NUM_SRC(NUM_SRC)
  ) u_ack (
    .clk    (clk),
    .rst    (rst),
    .fire   (accept),
    .id     (sel_q),
    .ack_out(src_ack)
  );

  ivg_gie_ctrl u_gie (
    .clk    (clk),
    .rst    (rst),
    .set_req(gie_set),
    .clr_req(gie_clr),
    .accept (accept),
    .gie_q  (gie_q)
  );

  // Capture on an idle edge, hold until the acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      vec_q  <= VEC_BASE;
    end else if (pend_q) begin
      if (irq_ack) pend_q <= 1'b0;
    end else if (win_valid) begin
      pend_q <= 1'b1;
      sel_q  <= win_id;
      vec_q  <= win_addr;
    end
  end

  assign irq_pending = pend_q;
  assign vec_addr    = vec_q;
  assign src_id      = sel_q;
  assign gie         = gie_q;
  assign win_is_nmi  = NMI_MASK[win_id];

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !irq_ack) |=> (pend_q && $stable(vec_q) && $stable(sel_q)));
  assert_ack_effects_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!pend_q && !gie_q && src_ack[sel_q]));
  assert_mask_by_gie_R4: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && win_valid && !gie_q) |-> win_is_nmi);
  assert_idle_vec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !win_valid) |=> (!pend_q && $stable(vec_q)));
  assert_ack_only_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (src_ack != '0) |-> $past(accept));
endmodule

// File: tb/test_irq_vector_gen.sv
module test_irq_vector_gen;
  localparam int N = 6;
  localparam int IDW = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   irq_req = '0;
  logic [N-1:0]   irq_en = '1;
  logic           gie_set = 1'b0;
  logic           gie_clr = 1'b0;
  logic           irq_ack = 1'b0;
  logic           irq_pending;
  logic [15:0]    vec_addr;
  logic [IDW-1:0] src_id;
  logic [N-1:0]   src_ack;
  logic           gie;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_gen i_irq_vector_gen (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .gie_set(gie_set), .gie_clr(gie_clr), .irq_ack(irq_ack),
    .irq_pending(irq_pending), .vec_addr(vec_addr), .src_id(src_id),
    .src_ack(src_ack), .gie(gie)
  );

  function automatic int prio_of(int i);
    case (i)
      0: return 60;
      1: return 59;
      2: return 54;
      3: return 53;
      4: return 49;
      default: return 48;
    endcase
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    cyc();
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk("R1 pending", 32'(irq_pending), 0);
    chk("R1 vec", 32'(vec_addr), 32'hFF80);
    chk("R1 id", 32'(src_id), 0);
    chk("R1 ack", 32'(src_ack), 0);
    chk("R1 gie", 32'(gie), 0);
  endtask

  task automatic t_mask();
    irq_req = 6'b011111;
    cyc(); cyc();
    chk("R4 maskable blocked by gie", 32'(irq_pending), 0);
    chk("R9 vec idle hold", 32'(vec_addr), 32'hFF80);
    irq_req = '0;
    gie_set = 1'b1; cyc(); gie_set = 1'b0;
    irq_en  = 6'b111101;
    irq_req = 6'b000010;
    cyc(); cyc();
    chk("R4 own enable blocks", 32'(irq_pending), 0);
    irq_req = '0; irq_en = '1;
    gie_clr = 1'b1; cyc(); gie_clr = 1'b0;
  endtask

  task automatic t_nmi();
    irq_en = 6'b011111;
    irq_req = 6'b100000;
    cyc(); cyc();
    chk("R5 nmi own enable blocks", 32'(irq_pending), 0);
    irq_en = '1;
    cyc();
    chk("R5 nmi bypasses gie", 32'(irq_pending), 1);
    chk("R2 vec src5", 32'(vec_addr), 32'hFFE0);
    chk("R6 id src5", 32'(src_id), 5);
    cyc(); cyc();
    chk("R6 held pending", 32'(irq_pending), 1);
    chk("R6 held vec", 32'(vec_addr), 32'hFFE0);
    do_ack();
    chk("R7 pending drops", 32'(irq_pending), 0);
    chk("R7 ack pulse", 32'(src_ack), 32'h20);
    chk("R9 vec kept after ack", 32'(vec_addr), 32'hFFE0);
    cyc();
    chk("R7 ack one cycle", 32'(src_ack), 0);
    chk("R11 re-presented", 32'(irq_pending), 1);
    do_ack();
    irq_req = '0;
    cyc();
    chk("R7 idle after second ack", 32'(irq_pending), 0);
  endtask

  task automatic t_gie();
    gie_set = 1'b1; cyc(); gie_set = 1'b0;
    chk("R10 set", 32'(gie), 1);
    gie_set = 1'b1; gie_clr = 1'b1; cyc(); gie_set = 1'b0; gie_clr = 1'b0;
    chk("R10 clear wins", 32'(gie), 0);
  endtask

  task automatic t_prio();
    gie_set = 1'b1; cyc(); gie_set = 1'b0;
    irq_req = 6'b011110;
    cyc();
    chk("R3 winner id", 32'(src_id), 1);
    chk("R3 winner vec", 32'(vec_addr), 32'hFFF6);
    irq_req = 6'b011111;
    cyc(); cyc();
    chk("R6 no preemption id", 32'(src_id), 1);
    chk("R6 no preemption vec", 32'(vec_addr), 32'hFFF6);
    gie_set = 1'b1;
    do_ack();
    gie_set = 1'b0;
    chk("R7 ack src1", 32'(src_ack), 32'h02);
    chk("R10 accept beats set", 32'(gie), 0);
    cyc();
    chk("R4 gie cleared masks", 32'(irq_pending), 0);
    gie_set = 1'b1; cyc(); gie_set = 1'b0;
    chk("R10 gie set, not yet pending", 32'(irq_pending), 0);
    cyc();
    chk("R3 top source id", 32'(src_id), 0);
    chk("R2 vec src0", 32'(vec_addr), 32'hFFF8);
    do_ack();
    irq_req = '0;
    cyc();
  endtask

  task automatic t_table();
    for (int i = 0; i < N; i++) begin
      gie_set = 1'b1; cyc(); gie_set = 1'b0;
      irq_req = N'(1) << i;
      cyc();
      chk($sformatf("R2 pending src%0d", i), 32'(irq_pending), 1);
      chk($sformatf("R2 vec src%0d", i), 32'(vec_addr), 32'hFF80 + 2 * prio_of(i));
      do_ack();
      irq_req = '0;
      cyc();
    end
  endtask

  task automatic t_idle_ack();
    gie_set = 1'b1; cyc(); gie_set = 1'b0;
    do_ack();
    chk("R8 no pulse", 32'(src_ack), 0);
    chk("R8 gie kept", 32'(gie), 1);
    chk("R8 no pending", 32'(irq_pending), 0);
    gie_clr = 1'b1; cyc(); gie_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_mask();
    t_nmi();
    t_gie();
    t_prio();
    t_table();
    t_idle_ack();
    finish_run();
  end
endmodule